// File: doc/BRIEF.md
# Debounced Comparator Detection Unit

This block qualifies a single-bit comparator output that arrives from an analog compare stage outside the chip. The raw level is first synchronized to the system clock. It is then sampled at one of four selectable rates. A detection is declared only after a programmable number of samples in a row have all been high. A sticky result flag records the detection so that software can poll it at leisure.

Software reaches the unit through one 16-bit control/status word. A write strobe loads the writable fields, and the read port always shows the current word. The word has a sampling-rate field, an enable bit, a sample-count field, a power-down bit that drives a strobe for the analog parts, and a read-only result flag. No data stream passes through the block, so neither edge has a valid/ready handshake. A write takes effect on the clock edge where the strobe is high, and there is no back-pressure.

Clearing the enable bit makes the result read zero at once and discards any partial run of high samples. Setting it again restarts the rate divider from its first phase.

Top module: `cmp_qualifier`

## Requirements
- R1: After reset the word reads 16'h0000 and `analog_pd_o` is 0.
- R2: A write loads bits 15:9 only. Bit 8 and bits 7:0 ignore written values. Bits 7:0 always read 0. Without a write strobe the word's writable bits hold their value.
- R3: Bits 15:14 set the sampling rate while enabled: 00 takes a sample on every clock, 01 on every 2nd, 10 on every 4th and 11 on every 8th. The divider counts from the first enabled cycle, so the first sample falls on enabled cycle 1, 2, 4 or 8.
- R4: Bits 12:10 set the number of samples needed. Values 0 to 4 require 1 to 5 samples, and values 5 to 7 require 5.
- R5: The result bit (bit 8) becomes 1 on the clock after the sample that completes the required run of high samples in a row. Any low sample restarts the run from zero.
- R6: Once set, the result stays 1 for as long as bit 13 (enable) stays 1, whatever the comparator does.
- R7: While bit 13 is 0, bit 8 reads 0. Clearing bit 13 also discards the run of high samples.
- R8: `analog_pd_o` equals the stored bit 9.
- R9: A change on `cmp_raw_i` goes through a two-flop synchronizer. With rate 00 and one required sample, a high level driven before edge k shows as result 1 after edge k+2.
- R10: The run counter saturates at its maximum and does not wrap back to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 16 | Value written to the control word |
| cfg_rd_data | output | 16 | Current control/status word |
| cmp_raw_i | input | 1 | Asynchronous comparator level |
| analog_pd_o | output | 1 | Power-down strobe for the analog compare stage |

## Verification
The bench builds the unit with a 4-bit run counter (`RUN_W = 4`) instead of the default 8 bits. With this setting, stretches of constant high input of a few dozen samples drive the counter into saturation, and the in-RTL saturation check is exercised there. The maximum sample count stays at 5, so the clamping of codes 5 to 7 is reachable. The synchronizer depth stays at two, which fixes the latency that the directed cases count against.

// File: rtl/cmpq_pkg.sv
package cmpq_pkg;
  localparam int WORD_W    = 16;
  localparam int RATE_W    = 2;
  localparam int NSAMP_W   = 3;
  localparam int RATE_LSB  = 14;
  localparam int EN_BIT    = 13;
  localparam int NSAMP_LSB = 10;
  localparam int PD_BIT    = 9;
  localparam int RES_BIT   = 8;
  localparam int DIV_W     = (1 << RATE_W) - 1;

  typedef struct packed {
    logic [RATE_W-1:0]  rate;
    logic               en;
    logic [NSAMP_W-1:0] nsamp;
    logic               pd;
  } ctrl_t;
endpackage

// File: rtl/cmpq_sync.sv
module cmpq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe_q[i] <= 1'b0;
          else        pipe_q[i] <= pipe_q[i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cmpq_ctrl_reg.sv
module cmpq_ctrl_reg
  import cmpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d       = ctrl_q;
    if (wr_en) begin
      ctrl_d.rate  = wr_data[RATE_LSB +: RATE_W];
      ctrl_d.en    = wr_data[EN_BIT];
      ctrl_d.nsamp = wr_data[NSAMP_LSB +: NSAMP_W];
      ctrl_d.pd    = wr_data[PD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;

  assign ctrl_o = ctrl_q;

  // R2
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/cmpq_prescale.sv
module cmpq_prescale
  import cmpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] phase_mask;

  always_comb begin
    phase_mask = '0;
    for (int b = 0; b < DIV_W; b++)
      if (b < int'(rate_i)) phase_mask[b] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     div_q <= '0;
    else if (!en_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;

  assign tick_o = en_i && ((div_q & phase_mask) == phase_mask);

  // R3
  no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && rate_i != '0) |=> (!tick_o || $changed(rate_i)));
endmodule

// File: rtl/cmpq_debounce.sv
module cmpq_debounce
  import cmpq_pkg::*;
#(
  parameter int RUN_W       = 8,
  parameter int MAX_SAMPLES = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               cmp_i,
  input  logic [NSAMP_W-1:0] nsamp_i,
  output logic               result_o
);
  localparam logic [RUN_W-1:0] RUN_MAX  = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] NEED_CAP = RUN_W'(MAX_SAMPLES - 1);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need_m1;
  logic             result_q;
  logic             hit;

  always_comb begin
    need_m1 = RUN_W'(nsamp_i);
    if (need_m1 > NEED_CAP) need_m1 = NEED_CAP;
  end

  assign hit = tick_i && cmp_i && (run_q >= need_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q    <= '0;
      result_q <= 1'b0;
    end else if (!en_i) begin
      run_q    <= '0;
      result_q <= 1'b0;
    end else if (tick_i) begin
      if (!cmp_i)                run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (hit) result_q <= 1'b1;
    end

  assign result_o = result_q;

  // R5
  low_sample_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !cmp_i) |=> (run_q == '0));
  // R6
  result_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && result_q) |=> result_q);
  // R7
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!result_q && run_q == '0));
  // R10
  run_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && cmp_i && run_q == RUN_MAX) |=> (run_q == RUN_MAX));
endmodule

// File: rtl/cmp_qualifier.sv
module cmp_qualifier
  import cmpq_pkg::*;
#(
  parameter int RUN_W       = 8,
  parameter int MAX_SAMPLES = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [WORD_W-1:0] cfg_wr_data,
  output logic [WORD_W-1:0] cfg_rd_data,
  input  logic              cmp_raw_i,
  output logic              analog_pd_o
);
  ctrl_t ctrl;
  logic  cmp_sync;
  logic  tick;
  logic  result;

  cmpq_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .ctrl_o  (ctrl)
  );

  cmpq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_sync)
  );

  cmpq_prescale u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ctrl.en),
    .rate_i (ctrl.rate),
    .tick_o (tick)
  );

  cmpq_debounce #(.RUN_W(RUN_W), .MAX_SAMPLES(MAX_SAMPLES)) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ctrl.en),
    .tick_i   (tick),
    .cmp_i    (cmp_sync),
    .nsamp_i  (ctrl.nsamp),
    .result_o (result)
  );

  always_comb begin
    cfg_rd_data                         = '0;
    cfg_rd_data[RATE_LSB +: RATE_W]     = ctrl.rate;
    cfg_rd_data[EN_BIT]                 = ctrl.en;
    cfg_rd_data[NSAMP_LSB +: NSAMP_W]   = ctrl.nsamp;
    cfg_rd_data[PD_BIT]                 = ctrl.pd;
    cfg_rd_data[RES_BIT]                = result && ctrl.en;
  end

  assign analog_pd_o = ctrl.pd;

  // R9
  result_needs_synced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result) |-> $past(cmp_sync));
endmodule

// File: tb/tb_cmp_qualifier.sv
module tb_cmp_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_W      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        cmp_raw_i = 1'b0;
  logic        analog_pd_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  cmp_qualifier #(.RUN_W(RUN_W), .MAX_SAMPLES(5), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cmp_raw_i(cmp_raw_i), .analog_pd_o(analog_pd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic       m_s1, m_s2, m_res;
  logic [6:0] m_reg;
  logic [2:0] m_div;
  int         m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_res <= 0; m_reg <= '0; m_div <= '0; m_run <= 0;
    end else begin
      automatic logic en   = m_reg[4];
      automatic int   per  = 1 << m_reg[6:5];
      automatic int   need = (m_reg[3:1] > 4) ? 5 : int'(m_reg[3:1]) + 1;
      automatic logic tick = en && ((int'(m_div) % per) == per - 1);
      m_s1 <= cmp_raw_i;
      m_s2 <= m_s1;
      if (cfg_wr_en) m_reg <= cfg_wr_data[15:9];
      m_div <= en ? m_div + 3'd1 : 3'd0;
      if (!en) begin
        m_run <= 0; m_res <= 0;
      end else if (tick) begin
        if (m_s2) begin
          m_run <= (m_run == (1 << RUN_W) - 1) ? m_run : m_run + 1;
          if (m_run + 1 >= need) m_res <= 1;
        end else m_run <= 0;
      end
    end
  end

  function automatic logic [15:0] exp_word();
    return {m_reg, m_res & m_reg[4], 8'h00};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    check(req, cfg_rd_data, exp_word());
    check("R8", {15'd0, analog_pd_o}, {15'd0, m_reg[0]});
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = $urandom;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cmp_raw_i = 1'b1;
      @(negedge clk);
    end
    cmp_raw_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1", cfg_rd_data, 16'h0000);
    check("R1", {15'd0, analog_pd_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R8: bit 8 and low byte ignore writes; pd strobe follows bit 9
    wr(16'h02FF);
    check("R2", cfg_rd_data, 16'h0200);
    check("R8", {15'd0, analog_pd_o}, 16'h0001);
    wr(16'h0000);
    check("R8", {15'd0, analog_pd_o}, 16'h0000);

    // R5: three samples needed at full rate
    wr(16'h2800);
    pulse(2);
    check("R5", cfg_rd_data, 16'h2800);
    pulse(3);
    check("R5", cfg_rd_data, 16'h2900);
    // R6: sticky while enabled
    repeat (10) @(negedge clk);
    check("R6", cfg_rd_data, 16'h2900);
    // R7: disable clears the flag
    wr(16'h0800);
    check("R7", cfg_rd_data, 16'h0800);
    // R7: partial run discarded when disabled
    wr(16'h2800);
    cmp_raw_i = 1'b1; repeat (2) @(negedge clk); cmp_raw_i = 1'b0;
    wr(16'h0800);
    wr(16'h2800);
    pulse(1);
    check("R7", cfg_rd_data, 16'h2800);

    // R4: codes above 4 clamp to five samples
    wr(16'h0000);
    wr(16'h3C00);
    pulse(4);
    check("R4", cfg_rd_data, 16'h3C00);
    pulse(5);
    check("R4", cfg_rd_data, 16'h3D00);

    // R9: synchronizer latency
    wr(16'h0000);
    wr(16'h2000);
    cmp_raw_i = 1'b1;
    @(negedge clk);
    check("R9", cfg_rd_data, 16'h2000);
    @(negedge clk);
    check("R9", cfg_rd_data, 16'h2000);
    @(negedge clk);
    check("R9", cfg_rd_data, 16'h2100);
    cmp_raw_i = 1'b0;

    // R3: each rate against the model, from enable rise
    for (int r = 0; r < 4; r++) begin
      wr(16'h0000);
      cmp_raw_i = 1'b1;
      repeat (3) @(negedge clk);
      wr(16'(r << 14) | 16'h2400);
      for (int i = 0; i < 24; i++) begin
        check_model("R3");
        @(negedge clk);
      end
      cmp_raw_i = 1'b0;
    end

    // R10: long high stretch drives the run counter into saturation
    wr(16'h3000);
    cmp_raw_i = 1'b1;
    for (int i = 0; i < 60; i++) begin
      check_model("R10");
      @(negedge clk);
    end
    cmp_raw_i = 1'b0;

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 149) == 0) begin
        cfg_wr_en = 1'b1;
        cfg_wr_data = $urandom;
        if ($urandom_range(0, 3) != 0) cfg_wr_data[13] = 1'b1;
      end else begin
        cfg_wr_en = 1'b0;
      end
      if ($urandom_range(0, 7) == 0) cmp_raw_i = ~cmp_raw_i;
      @(negedge clk);
      check_model("R5");
    end
    cfg_wr_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule